// File: doc/BRIEF.md
# Floating-Point NaN Classifier and Quieter

A purely combinational unit for one IEEE-754 binary operand. Three storage formats are supported, selected by a parameter: half (16 bits), single (32 bits) and double (64 bits). The unit reports whether the operand is a quiet NaN, a signaling NaN or neither. It also presents a quieted copy of the operand and the format's default NaN pattern. A floating-point datapath places it in front of its NaN propagation logic so that a signaling operand never leaves the unit unquieted.

Two parameters change how NaNs are read. `QUIET_HI` selects what a set quiet bit means: set means quiet, or set means signaling. `NO_SNAN` treats every NaN as quiet. A third parameter, `ALT_DFLT`, selects the alternate positive default NaN. The quiet bit is always the most significant fraction bit: bit 9 in half, bit 22 in single and bit 51 in double.

Top module: `fpnan_unit`

## Requirements
- R1: With `QUIET_HI`=1 and `NO_SNAN`=0, `is_qnan_o` is 1 exactly when the exponent field is all ones and the quiet bit (bit 9/22/51 for half/single/double) is 1.
- R2: With `QUIET_HI`=1 and `NO_SNAN`=0, `is_snan_o` is 1 exactly when the exponent field is all ones, the quiet bit is 0 and the fraction bits below the quiet bit are not all zero. Infinity (all-ones exponent, zero fraction) sets neither flag.
- R3: With `QUIET_HI`=0 and `NO_SNAN`=0, the two tests trade places. A NaN whose quiet bit is 1 reports as signaling. A NaN whose quiet bit is 0 and whose lower fraction is nonzero reports as quiet.
- R4: With `NO_SNAN`=1, every NaN (all-ones exponent, nonzero fraction) reports `is_qnan_o`=1, and `is_snan_o` is always 0.
- R5: With `QUIET_HI`=1, a signaling NaN comes out on `quieted_o` with the quiet bit set and every other bit, sign and payload included, unchanged.
- R6: With `QUIET_HI`=0, a signaling NaN comes out on `quieted_o` as the default NaN pattern.
- R7: Any operand that does not report as signaling appears on `quieted_o` unchanged. This covers zeros, infinities, finite values, quiet NaNs, and every operand when `NO_SNAN`=1.
- R8: `dflt_nan_o` is built as follows:
  - With `ALT_DFLT`=0 and `QUIET_HI`=1: sign 1, exponent all ones, quiet bit 1, rest 0 (single 0xFFC00000, half 0xFE00, double 0xFFF8000000000000).
  - With `ALT_DFLT`=0 and `QUIET_HI`=0: sign 0, exponent all ones, quiet bit 0, rest 1 (single 0x7FBFFFFF, half 0x7DFF).
  - With `ALT_DFLT`=1: sign 0, exponent all ones, quiet bit 1, rest 0 (single 0x7FC00000).
- R9: `is_qnan_o` and `is_snan_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | W (16/32/64 by FMT) | Operand to classify |
| is_qnan_o | output | 1 | Operand is a quiet NaN |
| is_snan_o | output | 1 | Operand is a signaling NaN |
| quieted_o | output | W | Quieted copy of the operand |
| dflt_nan_o | output | W | Default NaN pattern for this configuration |

## Verification
Five configurations are exercised side by side with the same stimulus:
- single precision in each polarity;
- single precision with the alternate default;
- half precision, inverted polarity;
- double precision, no-signaling mode.

Directed operands are signed zeros, both infinities and the largest finite value. These show that non-NaN values leave both flags clear and pass through unchanged. Quiet NaNs with only the quiet bit set and with a full fraction separate the two polarities. Signaling NaNs with payload 1 and with the maximum payload probe the lower-fraction nonzero boundary, where infinity ends and a NaN begins. Random operands, many forced to an all-ones exponent with sparse fractions, cover sign and payload preservation during quieting.

// File: rtl/fpnan_pkg.sv
package fpnan_pkg;

    // Format codes: 0 = half, 1 = single, 2 = double
    function automatic int fmt_exp(input int fmt);
        case (fmt)
            0:       return 5;
            1:       return 8;
            default: return 11;
        endcase
    endfunction

    function automatic int fmt_man(input int fmt);
        case (fmt)
            0:       return 10;
            1:       return 23;
            default: return 52;
        endcase
    endfunction

    function automatic int fmt_width(input int fmt);
        return 1 + fmt_exp(fmt) + fmt_man(fmt);
    endfunction

    typedef struct packed {
        logic nan;
        logic quiet;
        logic signaling;
    } nan_class_t;

endpackage

// File: rtl/fpnan_classify.sv
module fpnan_classify #(
    parameter int FMT      = 1,
    parameter int QUIET_HI = 1,
    parameter int NO_SNAN  = 0
) (
    input  logic [fpnan_pkg::fmt_width(FMT)-1:0] op_i,
    output fpnan_pkg::nan_class_t                cls_o
);
    localparam int EW = fpnan_pkg::fmt_exp(FMT);
    localparam int MW = fpnan_pkg::fmt_man(FMT);
    localparam int W  = fpnan_pkg::fmt_width(FMT);

    logic exp_full;
    logic frac_any;
    logic marks_quiet;

    always_comb begin
        exp_full    = &op_i[W-2 -: EW];
        frac_any    = |op_i[MW-1:0];
        // Polarity: does the top fraction bit read as "quiet"?
        marks_quiet = (QUIET_HI != 0) ? op_i[MW-1] : ~op_i[MW-1];

        cls_o.nan       = exp_full & frac_any;
        cls_o.quiet     = cls_o.nan & ((NO_SNAN != 0) | marks_quiet);
        cls_o.signaling = cls_o.nan & (NO_SNAN == 0) & ~marks_quiet;
    end

endmodule

// File: rtl/fpnan_dflt.sv
module fpnan_dflt #(
    parameter int FMT      = 1,
    parameter int QUIET_HI = 1,
    parameter int ALT_DFLT = 0
) (
    output logic [fpnan_pkg::fmt_width(FMT)-1:0] dflt_o
);
    localparam int EW = fpnan_pkg::fmt_exp(FMT);
    localparam int MW = fpnan_pkg::fmt_man(FMT);

    localparam logic SGN = (ALT_DFLT == 0) && (QUIET_HI != 0);
    localparam logic QB  = (ALT_DFLT != 0) || (QUIET_HI != 0);

    // Lower fraction is the complement of the quiet bit in every variant
    assign dflt_o = {SGN, {EW{1'b1}}, QB, {(MW-1){~QB}}};

endmodule

// File: rtl/fpnan_quiet.sv
module fpnan_quiet #(
    parameter int FMT      = 1,
    parameter int QUIET_HI = 1,
    parameter int ALT_DFLT = 0
) (
    input  logic [fpnan_pkg::fmt_width(FMT)-1:0] op_i,
    input  logic                                 snan_i,
    output logic [fpnan_pkg::fmt_width(FMT)-1:0] quieted_o,
    output logic [fpnan_pkg::fmt_width(FMT)-1:0] dflt_o
);
    localparam int MW = fpnan_pkg::fmt_man(FMT);
    localparam int W  = fpnan_pkg::fmt_width(FMT);
    localparam logic [W-1:0] QMASK = W'(1) << (MW - 1);

    fpnan_dflt #(
        .FMT      (FMT),
        .QUIET_HI (QUIET_HI),
        .ALT_DFLT (ALT_DFLT)
    ) u_dflt (
        .dflt_o (dflt_o)
    );

    generate
        if (QUIET_HI != 0) begin : g_setbit
            assign quieted_o = snan_i ? (op_i | QMASK) : op_i;
        end else begin : g_replace
            assign quieted_o = snan_i ? dflt_o : op_i;
        end
    endgenerate

endmodule

// File: rtl/fpnan_unit.sv
module fpnan_unit #(
    parameter int FMT      = 1,
    parameter int QUIET_HI = 1,
    parameter int NO_SNAN  = 0,
    parameter int ALT_DFLT = 0
) (
    input  logic [fpnan_pkg::fmt_width(FMT)-1:0] op_i,
    output logic                                 is_qnan_o,
    output logic                                 is_snan_o,
    output logic [fpnan_pkg::fmt_width(FMT)-1:0] quieted_o,
    output logic [fpnan_pkg::fmt_width(FMT)-1:0] dflt_nan_o
);
    localparam int EW = fpnan_pkg::fmt_exp(FMT);
    localparam int MW = fpnan_pkg::fmt_man(FMT);
    localparam int W  = fpnan_pkg::fmt_width(FMT);

    fpnan_pkg::nan_class_t cls;

    fpnan_classify #(
        .FMT      (FMT),
        .QUIET_HI (QUIET_HI),
        .NO_SNAN  (NO_SNAN)
    ) u_classify (
        .op_i  (op_i),
        .cls_o (cls)
    );

    fpnan_quiet #(
        .FMT      (FMT),
        .QUIET_HI (QUIET_HI),
        .ALT_DFLT (ALT_DFLT)
    ) u_quiet (
        .op_i      (op_i),
        .snan_i    (cls.signaling),
        .quieted_o (quieted_o),
        .dflt_o    (dflt_nan_o)
    );

    assign is_qnan_o = cls.quiet;
    assign is_snan_o = cls.signaling;

    // Cross-checks between the classifier and the quieting path
    always_comb begin
        assert_excl_R9: assert (!(cls.quiet && cls.signaling))
            else $error("quiet and signaling both set");
        if (cls.quiet || cls.signaling) begin
            assert_expfull_R1: assert (&op_i[W-2 -: EW])
                else $error("NaN flag with exponent not all ones");
        end
        if (!cls.signaling) begin
            assert_pass_R7: assert (quieted_o == op_i)
                else $error("non-signaling operand altered");
        end
        if (cls.signaling && QUIET_HI != 0) begin
            assert_qset_R5: assert (quieted_o[MW-1] &&
                                    quieted_o[W-1:MW] == op_i[W-1:MW] &&
                                    quieted_o[MW-2:0] == op_i[MW-2:0])
                else $error("quieting did not keep sign and payload");
        end
        if (cls.signaling && QUIET_HI == 0) begin
            assert_dflt_R6: assert (quieted_o == dflt_nan_o)
                else $error("inverted quieting did not give default NaN");
        end
        if (NO_SNAN != 0 && (&op_i[W-2 -: EW]) && (|op_i[MW-1:0])) begin
            assert_allquiet_R4: assert (cls.quiet)
                else $error("NaN not quiet in no-signaling mode");
        end
    end

endmodule

// File: tb/fpnan_unit_tb.sv
module fpnan_unit_tb;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int errors = 0;

    logic [31:0] op_s;
    logic [15:0] op_h;
    logic [63:0] op_d;

    logic        q_sn, s_sn, q_si, s_si, q_sa, s_sa, q_hi, s_hi, q_dn, s_dn;
    logic [31:0] o_sn, d_sn, o_si, d_si, o_sa, d_sa;
    logic [15:0] o_hi, d_hi;
    logic [63:0] o_dn, d_dn;

    fpnan_unit #(.FMT(1), .QUIET_HI(1), .NO_SNAN(0), .ALT_DFLT(0)) u_dut (
        .op_i(op_s), .is_qnan_o(q_sn), .is_snan_o(s_sn), .quieted_o(o_sn), .dflt_nan_o(d_sn));
    fpnan_unit #(.FMT(1), .QUIET_HI(0), .NO_SNAN(0), .ALT_DFLT(0)) u_dut_sinv (
        .op_i(op_s), .is_qnan_o(q_si), .is_snan_o(s_si), .quieted_o(o_si), .dflt_nan_o(d_si));
    fpnan_unit #(.FMT(1), .QUIET_HI(1), .NO_SNAN(0), .ALT_DFLT(1)) u_dut_salt (
        .op_i(op_s), .is_qnan_o(q_sa), .is_snan_o(s_sa), .quieted_o(o_sa), .dflt_nan_o(d_sa));
    fpnan_unit #(.FMT(0), .QUIET_HI(0), .NO_SNAN(0), .ALT_DFLT(0)) u_dut_hinv (
        .op_i(op_h), .is_qnan_o(q_hi), .is_snan_o(s_hi), .quieted_o(o_hi), .dflt_nan_o(d_hi));
    fpnan_unit #(.FMT(2), .QUIET_HI(1), .NO_SNAN(1), .ALT_DFLT(0)) u_dut_dnos (
        .op_i(op_d), .is_qnan_o(q_dn), .is_snan_o(s_dn), .quieted_o(o_dn), .dflt_nan_o(d_dn));

    function automatic logic [63:0] lomask(input int n);
        if (n >= 64) return '1;
        return (64'd1 << n) - 64'd1;
    endfunction

    // Operand builder: kinds 0..9 directed, 10..12 random shapes
    function automatic logic [63:0] pick(input int ew, input int mw, input int kind,
                                         input logic [63:0] r);
        int          w     = 1 + ew + mw;
        logic [63:0] sgn   = 64'd1 << (w - 1);
        logic [63:0] eones = lomask(ew) << mw;
        case (kind)
            0:  return 64'd0;                                  // +0
            1:  return sgn;                                    // -0
            2:  return eones;                                  // +inf
            3:  return sgn | eones;                            // -inf
            4:  return eones | (64'd1 << (mw - 1));            // quiet bit only
            5:  return eones | lomask(mw);                     // full fraction
            6:  return eones | 64'd1;                          // lower payload 1
            7:  return eones | lomask(mw - 1);                 // max lower payload
            8:  return sgn | eones | 64'd1;                    // negative payload 1
            9:  return ((lomask(ew) - 64'd1) << mw) | lomask(mw); // largest finite
            10: return r & lomask(w);
            11: return (r & (sgn | lomask(mw))) | eones;
            default: return (r[63] ? sgn : 64'd0) | eones | (r & 64'd3)
                            | (r[8] ? (64'd1 << (mw - 1)) : 64'd0);
        endcase
    endfunction

    task automatic check_one(input string tag, input int ew, input int mw,
                             input bit qone, input bit nosn, input logic [63:0] dflt,
                             input logic [63:0] v, input logic q, input logic s,
                             input logic [63:0] outv, input logic [63:0] dfl_out);
        int          w   = 1 + ew + mw;
        logic [63:0] sh  = (v << 1) & lomask(w);
        logic [63:0] thr = lomask(w) ^ lomask(w - ew - 1);
        bit hi_nan  = (sh >= thr);
        bit lo_nan  = (((v >> (mw - 1)) & lomask(ew + 1)) == (lomask(ew + 1) ^ 64'd1))
                      && ((v & lomask(mw - 1)) != 64'd0);
        bit eq, es;
        logic [63:0] eo;
        string rq, rs, ro;
        if (nosn) begin eq = hi_nan | lo_nan; es = 1'b0; rq = "R4"; rs = "R4"; end
        else if (qone) begin eq = hi_nan; es = lo_nan; rq = "R1"; rs = "R2"; end
        else begin eq = lo_nan; es = hi_nan; rq = "R3"; rs = "R3"; end
        if (es) begin
            eo = qone ? (v | (64'd1 << (mw - 1))) : dflt;
            ro = qone ? "R5" : "R6";
        end else begin
            eo = v;
            ro = "R7";
        end
        checks += 4;
        if (q !== eq) begin
            errors++;
            $display("FAIL %s %s qnan v=%h got %0b exp %0b", rq, tag, v, q, eq);
        end
        if (s !== es) begin
            errors++;
            $display("FAIL %s %s snan v=%h got %0b exp %0b", rs, tag, v, s, es);
        end
        if ((outv & lomask(w)) !== eo) begin
            errors++;
            $display("FAIL %s %s quieted v=%h got %h exp %h", ro, tag, v, outv, eo);
        end
        if ((q & s) !== 1'b0) begin   // R9
            errors++;
            $display("FAIL R9 %s both flags v=%h got q=%0b s=%0b exp not both", tag, v, q, s);
        end
        if ((dfl_out & lomask(w)) !== dflt) begin
            checks++;
            errors++;
            $display("FAIL R8 %s default got %h exp %h", tag, dfl_out, dflt);
        end
    endtask

    task automatic apply(input int kind, input logic [63:0] r);
        @(negedge clk);
        op_s = pick(8, 23, kind, r)[31:0];
        op_h = pick(5, 10, kind, r)[15:0];
        op_d = pick(11, 52, kind, r);
        #2;
        check_one("s_norm", 8, 23, 1, 0, 64'hFFC00000, {32'd0, op_s}, q_sn, s_sn,
                  {32'd0, o_sn}, {32'd0, d_sn});
        check_one("s_inv", 8, 23, 0, 0, 64'h7FBFFFFF, {32'd0, op_s}, q_si, s_si,
                  {32'd0, o_si}, {32'd0, d_si});
        check_one("s_alt", 8, 23, 1, 0, 64'h7FC00000, {32'd0, op_s}, q_sa, s_sa,
                  {32'd0, o_sa}, {32'd0, d_sa});
        check_one("h_inv", 5, 10, 0, 0, 64'h7DFF, {48'd0, op_h}, q_hi, s_hi,
                  {48'd0, o_hi}, {48'd0, d_hi});
        check_one("d_nosn", 11, 52, 1, 1, 64'hFFF8000000000000, op_d, q_dn, s_dn,
                  o_dn, d_dn);
    endtask

    initial begin
        op_s = '0; op_h = '0; op_d = '0;
        void'($urandom(32'd5171));
        // R8: default patterns checked explicitly once
        #2;
        checks += 5;
        if (d_sn !== 32'hFFC00000) begin errors++; $display("FAIL R8 s_norm got %h exp FFC00000", d_sn); end
        if (d_si !== 32'h7FBFFFFF) begin errors++; $display("FAIL R8 s_inv got %h exp 7FBFFFFF", d_si); end
        if (d_sa !== 32'h7FC00000) begin errors++; $display("FAIL R8 s_alt got %h exp 7FC00000", d_sa); end
        if (d_hi !== 16'h7DFF) begin errors++; $display("FAIL R8 h_inv got %h exp 7DFF", d_hi); end
        if (d_dn !== 64'hFFF8000000000000) begin errors++; $display("FAIL R8 d_nosn got %h exp FFF8000000000000", d_dn); end
        // Directed corners: zeros, infinities, NaN payload boundaries
        for (int k = 0; k < 10; k++) apply(k, 64'd0);
        // Constrained random
        for (int n = 0; n < 1500; n++) begin
            logic [63:0] r = {$urandom, $urandom};
            apply(10 + int'($urandom % 3), r);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired got running exp finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule